// File: doc/BRIEF.md
# Programmable Serial Clock Generator

This block drives the serial clock pin of a command-driven synchronous serial engine. It runs from the fast system clock and builds each half period from two stages: an optional divide-by-5 prescaler, then a 16-bit divisor. One clock pulse is two toggles of the output. The first toggle moves the output away from the idle level and the second brings it back, so the polarity of the pulse follows the programmed idle level. The block marks each toggle with a strobe that the data shifter uses to move or sample data.

A request asks for a counted burst of pulses. It can also run until a gate line reaches a chosen level, with or without a count limit. The shifter uses it for data commands and the command parser uses it for clock-only commands. Two timing variants are available. Three-phase timing adds a hold half period after each pulse. Adaptive timing stalls after every toggle until the clock returned from the target matches the driven level. All settings are captured when a request is accepted. Between requests the output follows the idle level supplied by the GPIO low byte.

Top module: `serclk_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `sclk_out`, `busy`, `done`, `lead_stb` and `trail_stb` are all low.
- R2: While no request runs, `sclk_out` takes the value `idle_lvl` had one clock earlier. After a burst completes, the output rests at the idle level that was captured when the burst was accepted.
- R3: The half period is H = (`cfg_div` + 1) × (5 if `cfg_pre_en` else 1) system clocks. The first toggle comes H clocks after the accepting edge. In two-phase, non-adaptive mode, consecutive toggles are exactly H clocks apart.
- R4: Each pulse is two toggles, and the first one leaves the idle level. `lead_stb` is high for one cycle together with the first toggle of each pulse, and `trail_stb` is high together with the second. The two strobes are never high at the same time.
- R5: A request with `req_forever` low and no gate match produces `req_cnt` + 1 pulses. `req_cnt` is CNT_W = 19 bits wide, so 0 gives 1 pulse and 524287 gives 524288 pulses.
- R6: With `cfg_3ph_en` high, a hold half period of H clocks follows every second toggle. The gap from a trailing toggle to the next leading toggle is then 2H.
- R7: With `cfg_adapt_en` high, the output does not change after a toggle until `rtck_in`, passed through a 2-flop synchronizer, equals `sclk_out`. If `rtck_in` is tied to `sclk_out`, every gap after a toggle grows by 3 clocks.
- R8: At the end of each pulse, when `req_gate_en` is high and `gate_in` equals `req_gate_lvl`, the burst stops. When `req_forever` is high, the count is ignored.
- R9: The configuration inputs are sampled only at acceptance. Changing them while `busy` is high has no effect on the running burst, and `req_valid` while busy is ignored.
- R10: `busy` is high from the accepting edge until completion. `done` is a single-cycle pulse at completion, and it is high only while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_div | input | 16 | Divisor; half period is (cfg_div+1) base ticks |
| cfg_pre_en | input | 1 | Enable divide-by-5 prescaler |
| cfg_3ph_en | input | 1 | Enable hold half period after each pulse |
| cfg_adapt_en | input | 1 | Wait for returned clock after each toggle |
| idle_lvl | input | 1 | Idle level of the clock between requests |
| req_valid | input | 1 | Request a burst (accepted when not busy) |
| req_cnt | input | 19 | Pulse count minus one |
| req_forever | input | 1 | Ignore the count; stop only on gate match |
| req_gate_en | input | 1 | Enable stopping on gate level |
| req_gate_lvl | input | 1 | Gate level that stops the burst |
| gate_in | input | 1 | Gate line, checked at the end of each pulse |
| rtck_in | input | 1 | Returned clock from the target |
| sclk_out | output | 1 | Serial clock output |
| lead_stb | output | 1 | Strobe with the first toggle of a pulse |
| trail_stb | output | 1 | Strobe with the second toggle of a pulse |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach is a burst stalled in the adaptive wait, because a returned clock tied to the output always catches up a few cycles later. The bench can force `rtck_in` to the level the output has just left. It holds that level for many cycles to show that no further toggle happens, then releases it and checks that the pulse finishes. A second hard case is a gate match landing inside one particular pulse of an unlimited burst. The bench counts toggles as they appear and raises `gate_in` between the leading and trailing toggle of the third pulse, so exactly three pulses are expected. Every combination of prescaler, divisor 0 to 3, three-phase and adaptive mode is swept, and each toggle gap is compared with the arithmetic value.

// File: rtl/serclk_pkg.sv
package serclk_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_WAIT = 2'd2
   } sc_state_e;

   typedef enum logic [1:0] {
      PH_LEAD  = 2'd0,
      PH_TRAIL = 2'd1,
      PH_HOLD  = 2'd2
   } sc_phase_e;
endpackage

// File: rtl/serclk_prescale.sv
module serclk_prescale #(
   parameter int P = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run_i,
   input  logic en_i,
   output logic tick_o
);
   if (P < 1) begin : g_bad
      $error("serclk_prescale: P must be at least 1");
   end

   if (P > 1) begin : g_div
      localparam int PW = $clog2(P);
      localparam logic [PW-1:0] LAST = PW'(P - 1);
      logic [PW-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)               cnt <= '0;
         else if (!run_i || !en_i) cnt <= '0;
         else if (cnt == LAST)     cnt <= '0;
         else                      cnt <= cnt + 1'b1;
      end

      assign tick_o = !en_i || (cnt == LAST);

      // with prescaling active, two base ticks are never adjacent
      AST_PRE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
         (run_i && en_i && $past(run_i) && $past(en_i) && tick_o) |-> !$past(tick_o)); // R3
   end else begin : g_pass
      assign tick_o = 1'b1;
   end
endmodule

// File: rtl/serclk_halftimer.sv
module serclk_halftimer #(
   parameter int DIV_W   = 16,
   parameter int PRE_DIV = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             pre_en_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             hdone_o
);
   logic             tick;
   logic [DIV_W-1:0] div_cnt;

   serclk_prescale #(.P(PRE_DIV)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (run_i),
      .en_i   (pre_en_i),
      .tick_o (tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      div_cnt <= '0;
      else if (!run_i) div_cnt <= '0;
      else if (tick)   div_cnt <= (div_cnt == div_i) ? '0 : div_cnt + 1'b1;
   end

   assign hdone_o = run_i && tick && (div_cnt == div_i);

   AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      run_i |-> (div_cnt <= div_i)); // R3
endmodule

// File: rtl/serclk_sync.sv
module serclk_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad
      $error("serclk_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[STAGES-2:0], d_i};
   end

   assign q_o = sh[STAGES-1];
endmodule

// File: rtl/serclk_gen.sv
module serclk_gen
   import serclk_pkg::*;
#(
   parameter int DIV_W       = 16,
   parameter int PRE_DIV     = 5,
   parameter int CNT_W       = 19,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] cfg_div,
   input  logic             cfg_pre_en,
   input  logic             cfg_3ph_en,
   input  logic             cfg_adapt_en,
   input  logic             idle_lvl,
   input  logic             req_valid,
   input  logic [CNT_W-1:0] req_cnt,
   input  logic             req_forever,
   input  logic             req_gate_en,
   input  logic             req_gate_lvl,
   input  logic             gate_in,
   input  logic             rtck_in,
   output logic             sclk_out,
   output logic             lead_stb,
   output logic             trail_stb,
   output logic             busy,
   output logic             done
);
   if (DIV_W < 1 || CNT_W < 1) begin : g_bad
      $error("serclk_gen: DIV_W and CNT_W must be positive");
   end

   sc_state_e        st_q;
   sc_phase_e        ph_q;
   logic [DIV_W-1:0] div_q;
   logic [CNT_W-1:0] rem_q;
   logic             pre_q, tph_q, ad_q, fev_q, gen_q, glv_q;
   logic             end_q, sclk_q, lead_q, trail_q, done_q;
   logic             run, hdone, rt_s, fin;

   assign run = (st_q == ST_RUN);

   serclk_halftimer #(.DIV_W(DIV_W), .PRE_DIV(PRE_DIV)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .run_i    (run),
      .pre_en_i (pre_q),
      .div_i    (div_q),
      .hdone_o  (hdone)
   );

   serclk_sync #(.STAGES(SYNC_STAGES)) u_rsync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (rtck_in),
      .q_o   (rt_s)
   );

   // end-of-pulse decision: count exhausted or gate level reached
   assign fin = (!fev_q && (rem_q == '0)) || (gen_q && (gate_in == glv_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         ph_q    <= PH_LEAD;
         div_q   <= '0;
         rem_q   <= '0;
         pre_q   <= 1'b0;
         tph_q   <= 1'b0;
         ad_q    <= 1'b0;
         fev_q   <= 1'b0;
         gen_q   <= 1'b0;
         glv_q   <= 1'b0;
         end_q   <= 1'b0;
         sclk_q  <= 1'b0;
         lead_q  <= 1'b0;
         trail_q <= 1'b0;
         done_q  <= 1'b0;
      end else begin
         lead_q  <= 1'b0;
         trail_q <= 1'b0;
         done_q  <= 1'b0;
         case (st_q)
            ST_IDLE: begin
               sclk_q <= idle_lvl;
               if (req_valid) begin
                  div_q <= cfg_div;
                  pre_q <= cfg_pre_en;
                  tph_q <= cfg_3ph_en;
                  ad_q  <= cfg_adapt_en;
                  fev_q <= req_forever;
                  gen_q <= req_gate_en;
                  glv_q <= req_gate_lvl;
                  rem_q <= req_cnt;
                  end_q <= 1'b0;
                  ph_q  <= PH_LEAD;
                  st_q  <= ST_RUN;
               end
            end
            ST_RUN: begin
               if (hdone) begin
                  case (ph_q)
                     PH_LEAD: begin
                        sclk_q <= ~sclk_q;
                        lead_q <= 1'b1;
                        ph_q   <= PH_TRAIL;
                        if (ad_q) st_q <= ST_WAIT;
                     end
                     PH_TRAIL: begin
                        sclk_q  <= ~sclk_q;
                        trail_q <= 1'b1;
                        if (tph_q) begin
                           ph_q <= PH_HOLD;
                           if (ad_q) st_q <= ST_WAIT;
                        end else begin
                           ph_q <= PH_LEAD;
                           if (!fin) rem_q <= rem_q - 1'b1;
                           if (ad_q) begin
                              st_q  <= ST_WAIT;
                              end_q <= fin;
                           end else if (fin) begin
                              st_q   <= ST_IDLE;
                              done_q <= 1'b1;
                           end
                        end
                     end
                     default: begin
                        ph_q <= PH_LEAD;
                        if (fin) begin
                           st_q   <= ST_IDLE;
                           done_q <= 1'b1;
                        end else begin
                           rem_q <= rem_q - 1'b1;
                        end
                     end
                  endcase
               end
            end
            ST_WAIT: begin
               if (rt_s == sclk_q) begin
                  if (end_q) begin
                     st_q   <= ST_IDLE;
                     done_q <= 1'b1;
                  end else begin
                     st_q <= ST_RUN;
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign sclk_out  = sclk_q;
   assign lead_stb  = lead_q;
   assign trail_stb = trail_q;
   assign busy      = (st_q != ST_IDLE);
   assign done      = done_q;

   AST_IDLE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(!busy)) |-> (sclk_out == $past(idle_lvl))); // R2

   AST_STB_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (lead_stb || trail_stb) |-> (sclk_out != $past(sclk_out))); // R4

   AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({lead_stb, trail_stb})); // R4

   AST_ADAPT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == ST_WAIT) && (rt_s != sclk_out)) |=> $stable(sclk_out)); // R7

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R10
endmodule

// File: tb/sim_serclk_gen.sv
module sim_serclk_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cfg_div = '0;
   logic        cfg_pre_en = 1'b0, cfg_3ph_en = 1'b0, cfg_adapt_en = 1'b0;
   logic        idle_lvl = 1'b0;
   logic        req_valid = 1'b0;
   logic [18:0] req_cnt = '0;
   logic        req_forever = 1'b0, req_gate_en = 1'b0, req_gate_lvl = 1'b0;
   logic        gate_in = 1'b0;
   logic        rt_force_en = 1'b0, rt_force_val = 1'b0;
   logic        rtck_in;
   logic        sclk_out, lead_stb, trail_stb, busy, done;

   assign rtck_in = rt_force_en ? rt_force_val : sclk_out;

   serclk_gen u0 (
      .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_pre_en(cfg_pre_en),
      .cfg_3ph_en(cfg_3ph_en), .cfg_adapt_en(cfg_adapt_en), .idle_lvl(idle_lvl),
      .req_valid(req_valid), .req_cnt(req_cnt), .req_forever(req_forever),
      .req_gate_en(req_gate_en), .req_gate_lvl(req_gate_lvl), .gate_in(gate_in),
      .rtck_in(rtck_in), .sclk_out(sclk_out), .lead_stb(lead_stb),
      .trail_stb(trail_stb), .busy(busy), .done(done)
   );

   always #10 clk = ~clk;

   int   cyc = 0;
   int   n_chk = 0, n_fail = 0;
   int   n_e = 0, n_lead = 0, n_trail = 0, n_done = 0;
   int   et [64];
   int   t0 = 0;
   logic lv0 = 1'b0, last_s = 1'b0;
   logic finished = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   // monitor: record toggle times and strobes, away from the active edge
   always @(negedge clk) begin
      if (sclk_out !== last_s) begin
         if (n_e < 64) et[n_e] = cyc;
         if (n_e == 0) lv0 = sclk_out;
         n_e++;
      end
      last_s = sclk_out;
      if (lead_stb)  n_lead++;
      if (trail_stb) n_trail++;
      if (done)      n_done++;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic int gap(input int k, input int h, input bit tph, input bit ad);
      int w;
      w = ad ? 3 : 0;
      if (k == 0) return h;
      if (k % 2 == 1) return h + w;
      return (tph ? 2 * h : h) + w;
   endfunction

   task automatic start_req(input bit pre, input int div, input bit tph, input bit ad,
                            input bit idl, input int cnt, input bit fev, input bit gen,
                            input bit glv);
      @(negedge clk);
      cfg_div = 16'(div); cfg_pre_en = pre; cfg_3ph_en = tph; cfg_adapt_en = ad;
      idle_lvl = idl;
      repeat (2) @(negedge clk);
      req_valid = 1'b1; req_cnt = 19'(cnt); req_forever = fev;
      req_gate_en = gen; req_gate_lvl = glv;
      @(posedge clk);
      #1;
      t0 = cyc; n_e = 0; n_lead = 0; n_trail = 0; n_done = 0;
      @(negedge clk);
      req_valid = 1'b0;
      chk(busy === 1'b1, "R10 busy after accept", int'(busy), 1);
   endtask

   task automatic wait_idle();
      int k;
      k = 0;
      while (busy && k < 20000) begin
         @(negedge clk);
         k++;
      end
      repeat (2) @(negedge clk);
   endtask

   task automatic verify_run(input int np, input int h, input bit tph, input bit ad,
                             input bit idl, input string tag);
      int bad, prev, g;
      string rq;
      rq = tph ? "R6" : (ad ? "R7" : "R3");
      chk(n_e == 2 * np, {"R5 toggle count ", tag}, n_e, 2 * np);
      bad = 0;
      prev = t0;
      for (int k = 0; k < n_e && k < 64; k++) begin
         g = gap(k, h, tph, ad);
         if (et[k] - prev != g) begin
            if (bad == 0)
               $display("FAIL %s gap k=%0d %s actual=%0d expected=%0d", rq, k, tag, et[k] - prev, g);
            bad++;
         end
         prev = et[k];
      end
      n_chk++;
      if (bad != 0) n_fail++;
      chk(lv0 == ~idl, {"R4 first toggle leaves idle ", tag}, int'(lv0), int'(~idl));
      chk(n_lead == np && n_trail == np, {"R4 strobe counts ", tag}, n_lead + n_trail, 2 * np);
      chk(sclk_out == idl, {"R2 rest at idle ", tag}, int'(sclk_out), int'(idl));
      chk(n_done == 1 && !busy, {"R10 single done ", tag}, n_done, 1);
   endtask

   // watchdog
   initial begin
      wait (cyc > 150000);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(sclk_out == 1'b0 && !busy && !done && !lead_stb && !trail_stb,
          "R1 in reset", int'({sclk_out, busy, done, lead_stb, trail_stb}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(sclk_out == 1'b0 && !busy && !done && !lead_stb && !trail_stb,
          "R1 after reset", int'({sclk_out, busy, done, lead_stb, trail_stb}), 0);

      // R2: idle following
      idle_lvl = 1'b1;
      @(negedge clk);
      chk(sclk_out == 1'b1, "R2 idle follows high", int'(sclk_out), 1);
      idle_lvl = 1'b0;
      @(negedge clk);
      chk(sclk_out == 1'b0, "R2 idle follows low", int'(sclk_out), 0);

      // sweep of all modes over small divisors (R3 R4 R6 R7)
      for (int pre = 0; pre < 2; pre++)
         for (int dv = 0; dv < 4; dv++)
            for (int tph = 0; tph < 2; tph++)
               for (int ad = 0; ad < 2; ad++) begin
                  int np, h;
                  bit idl;
                  np = 1 + ((dv + 2 * tph + ad) % 3);
                  h = (dv + 1) * (pre != 0 ? 5 : 1);
                  idl = bit'((dv + pre) % 2);
                  start_req(bit'(pre), dv, bit'(tph), bit'(ad), idl, np - 1, 1'b0, 1'b0, 1'b0);
                  wait_idle();
                  verify_run(np, h, bit'(tph), bit'(ad), idl,
                             $sformatf("pre=%0d div=%0d tph=%0d ad=%0d", pre, dv, tph, ad));
               end

      // R5 eight pulses with prescaler, and a long burst
      start_req(1'b1, 0, 1'b0, 1'b0, 1'b0, 7, 1'b0, 1'b0, 1'b0);
      wait_idle();
      verify_run(8, 5, 1'b0, 1'b0, 1'b0, "R5 eight");
      start_req(1'b0, 0, 1'b0, 1'b0, 1'b1, 1023, 1'b0, 1'b0, 1'b0);
      wait_idle();
      verify_run(1024, 1, 1'b0, 1'b0, 1'b1, "R5 long");

      // R8 gate already at level: stops after first pulse despite count 4
      gate_in = 1'b1;
      start_req(1'b0, 1, 1'b0, 1'b0, 1'b0, 4, 1'b0, 1'b1, 1'b1);
      wait_idle();
      verify_run(1, 2, 1'b0, 1'b0, 1'b0, "R8 gate first");
      // R8 gate level not matching: count limit applies
      start_req(1'b0, 1, 1'b0, 1'b0, 1'b0, 1, 1'b0, 1'b1, 1'b0);
      wait_idle();
      verify_run(2, 2, 1'b0, 1'b0, 1'b0, "R8 gate miss");
      gate_in = 1'b0;

      // R8 unlimited burst stopped by gate raised during pulse three
      start_req(1'b0, 1, 1'b0, 1'b0, 1'b0, 0, 1'b1, 1'b1, 1'b1);
      while (n_e < 5) begin
         @(negedge clk);
         #2;
      end
      gate_in = 1'b1;
      wait_idle();
      gate_in = 1'b0;
      verify_run(3, 2, 1'b0, 1'b0, 1'b0, "R8 forever gate");

      // R9 settings change and extra request while busy are ignored
      start_req(1'b0, 3, 1'b0, 1'b0, 1'b0, 2, 1'b0, 1'b0, 1'b0);
      while (n_e < 1) begin
         @(negedge clk);
         #2;
      end
      cfg_div = 16'd0; cfg_3ph_en = 1'b1; cfg_adapt_en = 1'b1; cfg_pre_en = 1'b1;
      req_valid = 1'b1; req_cnt = 19'd9;
      @(negedge clk);
      req_valid = 1'b0;
      wait_idle();
      verify_run(3, 4, 1'b0, 1'b0, 1'b0, "R9 config held");
      chk(!busy, "R9 no restart", int'(busy), 0);

      // R7 stall while returned clock stays at the old level
      rt_force_val = 1'b0;
      rt_force_en = 1'b1;
      start_req(1'b0, 0, 1'b0, 1'b1, 1'b0, 0, 1'b0, 1'b0, 1'b0);
      repeat (60) @(negedge clk);
      #2;
      chk(n_e == 1 && busy, "R7 stalled", n_e, 1);
      rt_force_en = 1'b0;
      wait_idle();
      chk(n_e == 2 && n_done == 1, "R7 resumes", n_e, 2);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule